// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (2 KB)

This block behaves as a 2048-byte serial EEPROM on a two-wire bus. It watches the clock and data lines of the bus, sampled into the core clock domain. It answers on the data line through an open-drain pull-down. A transaction opens with a start condition and a control byte. The control byte carries a fixed device identifier, the top three bits of the 11-bit byte address, and a read/write flag. A write transaction then takes one byte that sets the low address bits, followed by any number of data bytes. These data bytes fill a 16-byte page, and the address wraps inside that page. A read transaction streams bytes from the current address and moves through the whole array with wrap-around. It keeps streaming until the master declines to acknowledge a byte.

Every byte the slave accepts is acknowledged. A control byte with the wrong identifier is not acknowledged, and the slave then ignores the bus until the next start condition. A stop condition ends any transaction. The storage is an internal register array. Write-cycle delay and write protection are not modelled.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the slave is idle and does not pull the data line (`sda_pull_o` = 0).
- R2: With the clock line high, a falling data line is a start condition. It always begins reception of a control byte, even in the middle of a transaction (repeated start).
- R3: Received bits are taken on clock rising edges, most significant bit first. After the eighth bit the slave pulls data low from the next clock falling edge until the falling edge that follows, which is one acknowledge bit time.
- R4: A control byte whose bits 7:4 are not 4'b1010 gets no acknowledge. Bytes clocked after it, up to the next start condition, are neither acknowledged nor acted on.
- R5: Control byte bits 3:1 become address bits 10:8. Bit 0 = 1 starts a read at the current address, with those upper bits replaced.
- R6: In a write (control bit 0 = 0), the byte after the control byte sets address bits 7:0.
- R7: Each further data byte in a write is stored at the current address. Only address bits 3:0 then increment, so the address wraps within the 16-byte page.
- R8: In a read, data bits are presented on the line from clock falling edges, most significant bit first, as a pull for a 0 and a release for a 1. After each byte is loaded the address increments modulo 2048.
- R9: After each read byte the master's acknowledge bit is sampled. Low continues with the next byte. High ends the transaction, and the line stays released.
- R10: Outside an acknowledge bit or a read data bit of value 0, the slave never pulls the data line.
- R11: With the clock line high, a rising data line is a stop condition. It returns the slave to idle, so bytes clocked afterwards without a new start are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level (asynchronous) |
| sda_i | input | 1 | Bus data line level as seen on the wire (asynchronous) |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A wrong receive state or bit count shows at the ports within one byte time. In that case the acknowledge pull appears in the wrong bit slot or not at all. Every acknowledge slot and every data-bit slot is compared against the expected line level. A wrong address shows up later, as a wrong byte in a read. Reads are therefore placed to cross the page boundary written with wrap, the top of the array, and the locations a rejected or stopped transaction might have overwritten. Output timing is three core cycles after a bus clock edge, and the bench samples each low phase well after that.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W  = 11,
  parameter int PAGE_W  = 4,
  parameter logic [3:0] DEV_ID = 4'hA
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BLK_W = ADDR_W - 8;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_WR, S_SEND, S_RACK} st_t;

  st_t               state;
  logic [1:0]        scl_sync, sda_sync;
  logic              scl_q, sda_q;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        shreg, out_sr;
  logic [3:0]        bit_cnt, out_cnt;
  logic              sda_pull;
  logic [7:0]        mem [DEPTH];

  wire scl = scl_sync[1];
  wire sda = sda_sync[1];
  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start_c  = scl & scl_q & sda_q & ~sda;
  wire stop_c   = scl & scl_q & ~sda_q & sda;
  wire byte_in  = (bit_cnt == 4'd8) && (state inside {S_CMD, S_ADDR, S_WR});
  wire wr_en    = scl_fall && byte_in && state == S_WR;
  wire [ADDR_W-1:0] cmd_addr = {shreg[BLK_W:1], addr[7:0]};

  assign sda_pull_o = sda_pull;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl;
      sda_q    <= sda;
    end

  always_ff @(posedge clk)
    if (wr_en) mem[addr] <= shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= S_IDLE;
      addr     <= '0;
      shreg    <= '0;
      out_sr   <= '0;
      bit_cnt  <= '0;
      out_cnt  <= '0;
      sda_pull <= 1'b0;
    end else if (start_c) begin
      state    <= S_CMD;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else if (stop_c) begin
      state    <= S_IDLE;
      sda_pull <= 1'b0;
    end else if (scl_rise) begin
      case (state)
        S_RACK:
          if (sda) state <= S_IDLE;
          else begin
            state   <= S_SEND;
            out_sr  <= mem[addr];
            addr    <= addr + 1'b1;
            out_cnt <= '0;
          end
        S_CMD, S_ADDR, S_WR:
          if (!sda_pull) begin
            shreg   <= {shreg[6:0], sda};
            bit_cnt <= bit_cnt + 1'b1;
          end
        default: ;
      endcase
    end else if (scl_fall) begin
      if (byte_in) begin
        bit_cnt  <= '0;
        sda_pull <= 1'b1;
        case (state)
          S_CMD:
            if (shreg[7:4] != DEV_ID) begin
              state    <= S_IDLE;
              sda_pull <= 1'b0;
            end else if (shreg[0]) begin
              out_sr  <= mem[cmd_addr];
              addr    <= cmd_addr + 1'b1;
              out_cnt <= '0;
              state   <= S_SEND;
            end else begin
              addr  <= cmd_addr;
              state <= S_ADDR;
            end
          S_ADDR: begin
            addr[7:0] <= shreg;
            state     <= S_WR;
          end
          default: addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
        endcase
      end else if (state == S_SEND) begin
        if (out_cnt == 4'd8) begin
          state    <= S_RACK;
          sda_pull <= 1'b0;
        end else begin
          sda_pull <= ~out_sr[7];
          out_sr   <= {out_sr[6:0], 1'b0};
          out_cnt  <= out_cnt + 1'b1;
        end
      end else begin
        sda_pull <= 1'b0;
      end
    end

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE |-> !sda_pull);
  p_start_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> state == S_CMD && bit_cnt == 4'd0 && !sda_pull);
  p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> state == S_IDLE);
  p_pull_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> $past(scl_fall | start_c | stop_c));
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd8);
  p_bad_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && state == S_CMD && bit_cnt == 4'd8 && shreg[7:4] != DEV_ID)
      |=> state == S_IDLE && !sda_pull);
  p_page_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]) &&
              addr[PAGE_W-1:0] == PAGE_W'($past(addr[PAGE_W-1:0]) + 1'b1));
  p_read_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_rise && state == S_RACK && !sda) |=> addr == ADDR_W'($past(addr) + 1'b1));
endmodule

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb_top;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  wire  bus_sda = sda_m & ~sda_pull;

  int n_chk = 0, n_fail = 0;
  logic [7:0] ref_mem [0:2047];
  int ref_addr = 0;

  always #10 clk = ~clk;

  i2c_eeprom_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(bus_sda), .sda_pull_o(sda_pull)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic do_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic clk_bit(input logic b, output int seen);
    sda_m = b; wait_q();
    seen = int'(sda_pull);
    scl_m = 1'b1; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, input int exp_ack, input string req);
    int p;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(b[i], p);
      chk("R10 no pull while master sends", p, 0);
    end
    clk_bit(1'b1, p);
    chk(req, p, exp_ack);
  endtask

  task automatic read_body(input logic [2:0] blk, input int n);
    int p;
    logic [7:0] exp;
    send_byte({4'hA, blk, 1'b1}, 1, "R5 read control ack");
    ref_addr = {blk, ref_addr[7:0]};
    for (int k = 0; k < n; k++) begin
      exp = ref_mem[ref_addr];
      ref_addr = (ref_addr + 1) % 2048;
      for (int i = 7; i >= 0; i--) begin
        clk_bit(1'b1, p);
        chk("R8 read data bit", p, exp[i] ? 0 : 1);
      end
      clk_bit((k == n - 1) ? 1'b1 : 1'b0, p);
      chk("R9 line released in master ack slot", p, 0);
    end
    clk_bit(1'b1, p);
    chk("R9 released after no-ack", p, 0);
    do_stop();
  endtask

  task automatic wr_seq(input logic [10:0] a, input logic [7:0] d [$]);
    do_start();
    send_byte({4'hA, a[10:8], 1'b0}, 1, "R3 ack of control byte");
    send_byte(a[7:0], 1, "R6 ack of address byte");
    ref_addr = a;
    foreach (d[j]) begin
      send_byte(d[j], 1, "R7 ack of data byte");
      ref_mem[ref_addr] = d[j];
      ref_addr = {ref_addr[10:4], 4'(ref_addr[3:0] + 1)};
    end
    do_stop();
  endtask

  task automatic rd_rand(input logic [10:0] a, input int n);
    do_start();
    send_byte({4'hA, a[10:8], 1'b0}, 1, "R3 ack of control byte");
    send_byte(a[7:0], 1, "R6 ack of address byte");
    ref_addr = a;
    do_start();
    read_body(a[10:8], n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 released during reset", int'(sda_pull), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R1 released after reset", int'(sda_pull), 0);

    wr_seq(11'h23C, '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55});
    wr_seq(11'h7FE, '{8'hA1, 8'hA2});
    wr_seq(11'h000, '{8'hB1, 8'hB2, 8'hB3});

    rd_rand(11'h230, 1);
    rd_rand(11'h23C, 4);
    rd_rand(11'h7FE, 4);
    do_start();
    read_body(3'd0, 1);

    do_start();
    send_byte(8'hB0, 0, "R4 wrong identifier not acknowledged");
    send_byte(8'h00, 0, "R4 byte after rejected control ignored");
    send_byte(8'h77, 0, "R4 byte after rejected control ignored");
    do_stop();
    rd_rand(11'h000, 1);

    do_start();
    send_byte(8'hA0, 1, "R3 ack of control byte");
    send_byte(8'h01, 1, "R6 ack of address byte");
    do_stop();
    scl_m = 1'b0; wait_q();
    send_byte(8'h66, 0, "R11 byte after stop ignored");
    scl_m = 1'b1; wait_q();
    rd_rand(11'h001, 1);

    do_start();
    send_byte(8'hA2, 1, "R2 control after repeated start");
    send_byte(8'h3D, 1, "R6 ack of address byte");
    ref_addr = 11'h23D;
    do_start();
    read_body(3'd2, 2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule